// File: doc/BRIEF.md
# Multi-Mode Serial Video Lock Qualifier

This block decides when a serial video receiver may report lock. It reads the recovered-clock PLL status, a signal-presence flag and the receiver's operating mode. In the raw pass-through mode, PLL lock alone is enough. In the framed video mode it also requires a pair of timing-reference (TRS) words that arrive close together in time. When noise immunity is on, that pair must also share one word-alignment position. In the asynchronous serial interface (ASI) mode it requires a run of error-free words inside a bounded window of received words.

A standby input freezes the whole block: the lock flag and every internal counter keep their state. Losing the PLL or the input signal outside standby drops the lock flag and clears all qualification progress. The upstream decoders supply one-cycle strobes for each detected TRS word, each received ASI word and each line boundary. A TRS strobe comes with its alignment position, and an ASI word strobe comes with its error flag. `locked_o` is registered: after every rising clock edge it shows the decision made from the inputs sampled at that edge.

Top module: `video_lock_qualifier`

## Requirements
- R1: While `rst` is high, and after it is released, `locked_o` is low until a lock condition is met.
- R2: With mode bits {`bypass_i`,`asi_mode_i`} = 2'b00, PLL lock and signal valid, `locked_o` is high after the next edge.
- R3: With {`bypass_i`,`asi_mode_i`} = 2'b10, `locked_o` rises at the edge that samples a second TRS strobe arriving before LINE_WIN (2) line strobes have followed the previous TRS. A TRS coinciding with a line strobe counts as a TRS only.
- R4: When LINE_WIN line strobes follow the latest TRS with no TRS among them, the pair count returns to zero and `locked_o` falls at that edge. The next TRS is then only a first word.
- R5: When `noise_imm_i` and `auto_i` are both high, a TRS whose `trs_align_i` differs from the previous TRS clears `locked_o` and becomes the new first word.
- R6: With `auto_i` low, `trs_align_i` and `noise_imm_i` have no effect.
- R7: With {`bypass_i`,`asi_mode_i`} = 2'b01, `locked_o` rises at the edge that samples the RUN_LEN-th (32nd) consecutive ASI word strobe with `asi_err_i` low.
- R8: An ASI word strobe with `asi_err_i` high resets the good-word run and clears `locked_o`.
- R9: Every WIN_LEN (128) ASI words without a completed run close the window and reset the run. A run that completes on the window's last word still locks.
- R10: While `standby_i` is high, `locked_o` and all qualification state keep their values whatever the other inputs do.
- R11: Outside standby, `sig_valid_i` low drives `locked_o` low at the next edge and clears all qualification state.
- R12: Outside standby, `pll_lock_i` low drives `locked_o` low at the next edge and clears all qualification state.
- R13: Mode 2'b11 keeps `locked_o` low. The qualifier of a mode that is not selected is held cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_lock_i | input | 1 | Recovered-clock PLL reports lock |
| sig_valid_i | input | 1 | A valid serial input is present |
| bypass_i | input | 1 | Mode bit: framed video processing enabled |
| asi_mode_i | input | 1 | Mode bit: ASI reception selected |
| auto_i | input | 1 | Automatic rate search (high) or manual (low) |
| noise_imm_i | input | 1 | Require equal alignment for TRS pairs |
| standby_i | input | 1 | Freeze lock flag and qualification state |
| trs_stb_i | input | 1 | One-cycle strobe per detected TRS word |
| trs_align_i | input | ALIGN_W | Alignment position of the strobed TRS |
| line_stb_i | input | 1 | One-cycle strobe per line boundary |
| asi_word_stb_i | input | 1 | One-cycle strobe per received ASI word |
| asi_err_i | input | 1 | The strobed ASI word carried an error |
| locked_o | output | 1 | Registered lock decision |

## Verification
The TRS path is driven with pairs inside and outside the two-line window and with a TRS that coincides with a line strobe. This separates a correct window count from an off-by-one in either direction. Alignment sequences are run with noise immunity in automatic and in manual mode, so that a check applied in manual mode, or skipped in automatic mode, shows up. For ASI, error-separated runs of 31 words are used to push a run across a window boundary: a run finishing on word 128 must lock, and one that straddles the boundary must not. Constrained random cycles then mix mode changes, PLL drops, standby and all strobes, and compare every cycle against a word-level model.

// File: rtl/vlq_pkg.sv
package vlq_pkg;

    localparam int unsigned ALIGN_W_DEF  = 4;
    localparam int unsigned LINE_WIN_DEF = 2;
    localparam int unsigned RUN_LEN_DEF  = 32;
    localparam int unsigned WIN_LEN_DEF  = 128;

    // encoding is {bypass, asi}
    typedef enum logic [1:0] {
        MODE_THRU  = 2'b00,
        MODE_ASI   = 2'b01,
        MODE_SMPTE = 2'b10,
        MODE_BAD   = 2'b11
    } vlq_mode_e;

    typedef struct packed {
        logic trs_clr;
        logic asi_clr;
        logic hold;
    } vlq_ctl_t;

    function automatic vlq_mode_e decode_mode(input logic bypass, input logic asi);
        return vlq_mode_e'({bypass, asi});
    endfunction

endpackage

// File: rtl/vlq_trs_qual.sv
module vlq_trs_qual #(
    parameter int unsigned ALIGN_W  = vlq_pkg::ALIGN_W_DEF,
    parameter int unsigned LINE_WIN = vlq_pkg::LINE_WIN_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic               clr,
    input  logic               align_chk,
    input  logic               trs_stb_i,
    input  logic [ALIGN_W-1:0] trs_align_i,
    input  logic               line_stb_i,
    output logic               ok_next
);
    localparam int unsigned LW = $clog2(LINE_WIN + 1);

    logic               have_q, have_n;
    logic [LW-1:0]      lines_q, lines_n;
    logic [ALIGN_W-1:0] align_q, align_n;
    logic               ok_q, ok_n;

    always_comb begin
        have_n  = have_q;
        lines_n = lines_q;
        align_n = align_q;
        ok_n    = ok_q;
        if (clr) begin
            have_n  = 1'b0;
            lines_n = '0;
            align_n = '0;
            ok_n    = 1'b0;
        end else if (trs_stb_i) begin
            lines_n = '0;
            align_n = trs_align_i;
            if (!have_q) begin
                have_n = 1'b1;
            end else if (align_chk && (trs_align_i != align_q)) begin
                ok_n = 1'b0;
            end else begin
                ok_n = 1'b1;
            end
        end else if (line_stb_i && have_q) begin
            if (lines_q == LW'(LINE_WIN - 1)) begin
                have_n  = 1'b0;
                lines_n = '0;
                ok_n    = 1'b0;
            end else begin
                lines_n = lines_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q  <= 1'b0;
            lines_q <= '0;
            align_q <= '0;
            ok_q    <= 1'b0;
        end else if (!hold) begin
            have_q  <= have_n;
            lines_q <= lines_n;
            align_q <= align_n;
            ok_q    <= ok_n;
        end
    end

    assign ok_next = hold ? ok_q : ok_n;

    // R3
    trs_rise_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_q) |-> $past(trs_stb_i));

    // R4
    trs_window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        lines_q < LW'(LINE_WIN));

    // R10
    trs_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(hold) && !$past(rst)) |-> ($stable(lines_q) && $stable(have_q)));

endmodule

// File: rtl/vlq_asi_qual.sv
module vlq_asi_qual #(
    parameter int unsigned RUN_LEN = vlq_pkg::RUN_LEN_DEF,
    parameter int unsigned WIN_LEN = vlq_pkg::WIN_LEN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic clr,
    input  logic word_stb_i,
    input  logic err_i,
    output logic ok_next
);
    localparam int unsigned RW = $clog2(RUN_LEN + 1);
    localparam int unsigned WW = $clog2(WIN_LEN);

    logic [RW-1:0] run_q, run_n;
    logic [WW-1:0] win_q, win_n;
    logic          ok_q, ok_n;

    always_comb begin
        run_n = run_q;
        win_n = win_q;
        ok_n  = ok_q;
        if (clr) begin
            run_n = '0;
            win_n = '0;
            ok_n  = 1'b0;
        end else if (word_stb_i) begin
            if (err_i) begin
                run_n = '0;
                ok_n  = 1'b0;
            end else if (run_q >= RW'(RUN_LEN - 1)) begin
                run_n = RW'(RUN_LEN);
                ok_n  = 1'b1;
            end else begin
                run_n = run_q + 1'b1;
            end
            if (ok_n) begin
                win_n = '0;
            end else if (win_q == WW'(WIN_LEN - 1)) begin
                win_n = '0;
                run_n = '0;
            end else begin
                win_n = win_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            win_q <= '0;
            ok_q  <= 1'b0;
        end else if (!hold) begin
            run_q <= run_n;
            win_q <= win_n;
            ok_q  <= ok_n;
        end
    end

    assign ok_next = hold ? ok_q : ok_n;

    // R7
    asi_rise_needs_good_word_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_q) |-> $past(word_stb_i && !err_i));

    // R8
    asi_err_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(word_stb_i && err_i && !hold) && !$past(rst)) |-> (!ok_q && run_q == '0));

    // R9
    asi_run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q <= RW'(RUN_LEN));

endmodule

// File: rtl/vlq_lock_ctrl.sv
module vlq_lock_ctrl
    import vlq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  vlq_mode_e mode,
    input  logic      pll_lock_i,
    input  logic      sig_valid_i,
    input  logic      standby_i,
    input  logic      trs_ok,
    input  logic      asi_ok,
    output vlq_ctl_t  ctl,
    output logic      locked_o
);
    logic good_in;
    logic locked_q, locked_n;

    assign good_in = pll_lock_i && sig_valid_i;

    always_comb begin
        ctl.hold    = standby_i;
        ctl.trs_clr = !good_in || (mode != MODE_SMPTE);
        ctl.asi_clr = !good_in || (mode != MODE_ASI);
        unique case (mode)
            MODE_THRU:  locked_n = good_in;
            MODE_SMPTE: locked_n = good_in && trs_ok;
            MODE_ASI:   locked_n = good_in && asi_ok;
            default:    locked_n = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)             locked_q <= 1'b0;
        else if (!standby_i) locked_q <= locked_n;
    end

    assign locked_o = locked_q;

    // R10
    standby_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(standby_i) && !$past(rst)) |-> $stable(locked_q));

    // R11
    no_signal_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (!standby_i && !sig_valid_i) |=> !locked_q);

    // R12
    pll_loss_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (!standby_i && !pll_lock_i) |=> !locked_q);

    // R2
    thru_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (!standby_i && good_in && mode == MODE_THRU) |=> locked_q);

    // R13
    bad_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (!standby_i && mode == MODE_BAD) |=> !locked_q);

endmodule

// File: rtl/video_lock_qualifier.sv
module video_lock_qualifier
    import vlq_pkg::*;
#(
    parameter int unsigned ALIGN_W  = ALIGN_W_DEF,
    parameter int unsigned LINE_WIN = LINE_WIN_DEF,
    parameter int unsigned RUN_LEN  = RUN_LEN_DEF,
    parameter int unsigned WIN_LEN  = WIN_LEN_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pll_lock_i,
    input  logic               sig_valid_i,
    input  logic               bypass_i,
    input  logic               asi_mode_i,
    input  logic               auto_i,
    input  logic               noise_imm_i,
    input  logic               standby_i,
    input  logic               trs_stb_i,
    input  logic [ALIGN_W-1:0] trs_align_i,
    input  logic               line_stb_i,
    input  logic               asi_word_stb_i,
    input  logic               asi_err_i,
    output logic               locked_o
);
    vlq_mode_e mode;
    vlq_ctl_t  ctl;
    logic      trs_ok, asi_ok;

    assign mode = decode_mode(bypass_i, asi_mode_i);

    vlq_trs_qual #(.ALIGN_W(ALIGN_W), .LINE_WIN(LINE_WIN)) u_trs (
        .clk         (clk),
        .rst         (rst),
        .hold        (ctl.hold),
        .clr         (ctl.trs_clr),
        .align_chk   (noise_imm_i && auto_i),
        .trs_stb_i   (trs_stb_i),
        .trs_align_i (trs_align_i),
        .line_stb_i  (line_stb_i),
        .ok_next     (trs_ok)
    );

    vlq_asi_qual #(.RUN_LEN(RUN_LEN), .WIN_LEN(WIN_LEN)) u_asi (
        .clk        (clk),
        .rst        (rst),
        .hold       (ctl.hold),
        .clr        (ctl.asi_clr),
        .word_stb_i (asi_word_stb_i),
        .err_i      (asi_err_i),
        .ok_next    (asi_ok)
    );

    vlq_lock_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .pll_lock_i  (pll_lock_i),
        .sig_valid_i (sig_valid_i),
        .standby_i   (standby_i),
        .trs_ok      (trs_ok),
        .asi_ok      (asi_ok),
        .ctl         (ctl),
        .locked_o    (locked_o)
    );

endmodule

// File: tb/video_lock_qualifier_bench.sv
module video_lock_qualifier_bench;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pll = 1'b0, valid = 1'b0, byp = 1'b0, asim = 1'b0;
    logic autom = 1'b1, nimm = 1'b0, stby = 1'b0;
    logic trs = 1'b0, line = 1'b0, word = 1'b0, err = 1'b0;
    logic [AW-1:0] align = '0;
    logic locked;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    video_lock_qualifier u_video_lock_qualifier (
        .clk(clk), .rst(rst), .pll_lock_i(pll), .sig_valid_i(valid),
        .bypass_i(byp), .asi_mode_i(asim), .auto_i(autom), .noise_imm_i(nimm),
        .standby_i(stby), .trs_stb_i(trs), .trs_align_i(align), .line_stb_i(line),
        .asi_word_stb_i(word), .asi_err_i(err), .locked_o(locked)
    );

    // word-level reference model, stepped on every rising edge
    int m_have, m_lines, m_align, m_tok, m_run, m_win, m_aok, m_lock;

    function automatic int lock_decision(int md, int good, int tok, int aok);
        if (!good) return 0;
        case (md)
            0: return 1;
            2: return tok;
            1: return aok;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int md, good;
        md   = {byp, asim};
        good = (pll && valid) ? 1 : 0;
        if (rst) begin
            m_have = 0; m_lines = 0; m_align = 0; m_tok = 0;
            m_run = 0; m_win = 0; m_aok = 0; m_lock = 0;
        end else if (!stby) begin
            if (!good || md != 2) begin
                m_have = 0; m_lines = 0; m_align = 0; m_tok = 0;
            end else if (trs) begin
                if (m_have == 0) m_have = 1;
                else if (nimm && autom && int'(align) != m_align) m_tok = 0;
                else m_tok = 1;
                m_lines = 0;
                m_align = int'(align);
            end else if (line && m_have != 0) begin
                m_lines++;
                if (m_lines >= 2) begin m_have = 0; m_lines = 0; m_tok = 0; end
            end
            if (!good || md != 1) begin
                m_run = 0; m_win = 0; m_aok = 0;
            end else if (word) begin
                if (err) begin m_run = 0; m_aok = 0; end
                else begin
                    if (m_run < 32) m_run++;
                    if (m_run >= 32) m_aok = 1;
                end
                if (m_aok != 0) m_win = 0;
                else begin
                    m_win++;
                    if (m_win >= 128) begin m_win = 0; m_run = 0; end
                end
            end
            m_lock = lock_decision(md, good, m_tok, m_aok);
        end
    end

    task automatic chk(string req, logic exp);
        n_cmp++;
        if (locked !== exp) begin
            n_bad++;
            $display("FAIL %s: locked_o actual %0b expected %0b at %0t", req, locked, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        trs = 1'b0; line = 1'b0; word = 1'b0; err = 1'b0;
    endtask

    task automatic send_trs(logic [AW-1:0] a, logic with_line);
        trs = 1'b1; align = a; line = with_line; step();
    endtask

    task automatic send_line();
        line = 1'b1; step();
    endtask

    task automatic send_words(int n, logic e);
        for (int i = 0; i < n; i++) begin word = 1'b1; err = e; step(); end
    endtask

    task automatic flush();
        pll = 1'b0; step(); pll = 1'b1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk); @(negedge clk);
        chk("R1", 1'b0);
        rst = 1'b0;
        step();
        chk("R1", 1'b0);

        // data-through
        pll = 1'b1; valid = 1'b1; step();
        chk("R2", 1'b1);
        pll = 1'b0; step();
        chk("R12", 1'b0);
        pll = 1'b1; valid = 1'b0; step();
        chk("R11", 1'b0);
        valid = 1'b1; byp = 1'b1; asim = 1'b1; step();
        chk("R13", 1'b0);

        // SMPTE pair and window
        asim = 1'b0; step();
        chk("R13", 1'b0);
        send_trs(4'd0, 1'b0); chk("R3", 1'b0);
        send_line();          chk("R3", 1'b0);
        send_trs(4'd0, 1'b1); chk("R3", 1'b1);
        send_line();          chk("R4", 1'b1);
        send_line();          chk("R4", 1'b0);
        send_trs(4'd5, 1'b0); chk("R4", 1'b0);
        send_trs(4'd5, 1'b0); chk("R4", 1'b1);

        // alignment in auto mode
        flush(); nimm = 1'b1; autom = 1'b1;
        send_trs(4'd1, 1'b0); chk("R5", 1'b0);
        send_trs(4'd2, 1'b0); chk("R5", 1'b0);
        send_trs(4'd2, 1'b0); chk("R5", 1'b1);
        send_trs(4'd3, 1'b0); chk("R5", 1'b0);
        send_trs(4'd3, 1'b0); chk("R5", 1'b1);

        // alignment ignored in manual mode
        flush(); autom = 1'b0;
        send_trs(4'd1, 1'b0); chk("R6", 1'b0);
        send_trs(4'd2, 1'b0); chk("R6", 1'b1);
        send_trs(4'd7, 1'b0); chk("R6", 1'b1);

        // standby freeze
        stby = 1'b1; pll = 1'b0; valid = 1'b0;
        send_line(); send_line(); send_line();
        chk("R10", 1'b1);
        pll = 1'b1; valid = 1'b1; stby = 1'b0;
        send_line(); chk("R10", 1'b1);
        send_line(); chk("R4", 1'b0);
        stby = 1'b1; pll = 1'b1; step();
        send_trs(4'd0, 1'b0); send_trs(4'd0, 1'b0);
        chk("R10", 1'b0);
        stby = 1'b0; autom = 1'b1; nimm = 1'b0;

        // ASI
        byp = 1'b0; asim = 1'b1; flush();
        send_words(31, 1'b0); chk("R7", 1'b0);
        send_words(1, 1'b0);  chk("R7", 1'b1);
        send_words(5, 1'b0);  chk("R7", 1'b1);
        send_words(1, 1'b1);  chk("R8", 1'b0);
        send_words(31, 1'b0); chk("R8", 1'b0);
        send_words(1, 1'b0);  chk("R8", 1'b1);

        // run ending on the 128th word of a window
        flush();
        for (int g = 0; g < 3; g++) begin send_words(31, 1'b0); send_words(1, 1'b1); end
        send_words(32, 1'b0); chk("R9", 1'b1);

        // run straddling the window end
        flush();
        for (int g = 0; g < 3; g++) begin send_words(31, 1'b0); send_words(1, 1'b1); end
        send_words(1, 1'b1);
        send_words(31, 1'b0); chk("R9", 1'b0);
        send_words(31, 1'b0); chk("R9", 1'b0);
        send_words(1, 1'b0);  chk("R9", 1'b1);

        // constrained random against the model
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(199) == 0) {byp, asim} = 2'($urandom_range(3));
            if ($urandom_range(149) == 0) pll = ~pll;
            if ($urandom_range(299) == 0) valid = ~valid;
            if ($urandom_range(249) == 0) stby = ~stby;
            if ($urandom_range(299) == 0) autom = ~autom;
            if ($urandom_range(299) == 0) nimm = ~nimm;
            if (!pll && $urandom_range(3) == 0) pll = 1'b1;
            if (!valid && $urandom_range(3) == 0) valid = 1'b1;
            if (stby && $urandom_range(9) == 0) stby = 1'b0;
            trs   = ($urandom_range(3) == 0);
            align = AW'($urandom_range(1));
            line  = ($urandom_range(5) == 0);
            word  = ($urandom_range(7) != 0);
            err   = ($urandom_range(59) == 0);
            step();
            chk("R3 R4 R5 R7 R8 R9 R10 R11 R12 R13 random", m_lock[0]);
        end
        finish_run();
    end
endmodule